// File: doc/BRIEF.md
# Handshaked Euclidean GCD Unit

This block finds the greatest common divisor of two unsigned operands. It works by repeated swap and subtract steps, one step per clock. A producer hands over an operand pair through a valid/ready handshake. The unit works on that pair alone until a consumer takes the result through a second valid/ready handshake. Only then is a new pair accepted.

The logic is split into a datapath and a three-state controller. The datapath holds two operand registers, one subtractor, one less-than comparator and one zero detector. The controller moves through three states: idle, iterate and result-held. In the iterate state it picks one action per cycle:

- If the first register is below the second, the two registers swap.
- Otherwise, if the second register is nonzero, the first register takes its own value minus the second.
- Otherwise the first register holds the answer, and the controller moves on.

Top module: `gcd_unit`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, out_valid_o is 0 and in_ready_o is 1.
- R2: in_ready_o is 1 only while the unit is idle. It drops in the cycle after an accepted pair and stays 0 until the result has been taken.
- R3: A pair is captured only on a rising edge where in_valid_i and in_ready_o are both 1. While the unit is busy, in_valid_i, in_a_i and in_b_i have no effect on the result being computed.
- R4: For two nonzero operands, out_gcd_o equals their greatest common divisor.
- R5: When both operands are zero the result is 0. When exactly one operand is zero the result is the other operand.
- R6: Each iterate cycle performs exactly one swap or one subtract, or ends the iteration. out_valid_o therefore rises N+1 edges after the accepting edge, where N is the number of swaps plus subtracts. The pair 32, 48 takes 6 steps (swap, subtract, swap, subtract, subtract, swap) and yields 16 after 7 edges.
- R7: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_gcd_o stays unchanged. After an edge with both signals at 1, out_valid_o is 0 and in_ready_o is 1.
- R8: in_ready_o and out_valid_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operand pair offered |
| in_ready_o | output | 1 | Unit idle and able to take a pair |
| in_a_i | input | WIDTH | First operand |
| in_b_i | input | WIDTH | Second operand |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer takes the result |
| out_gcd_o | output | WIDTH | Greatest common divisor |

## Verification
The checker relies on three things about the inputs.

- The producer does not need its pair to be taken while the unit is busy.
- out_ready_i is free to stall the result for any number of cycles.
- The captured operands stay fixed from acceptance to delivery, which lets the checker test the divisibility of the result against them.

The directed tasks keep within these limits. They raise in_valid_i with scrambled operands only while in_ready_o is low, and drop in_valid_i before releasing a result. They insert random idle gaps and random stalls on out_ready_i. The operand width is reduced in the bench so that every subtract chain stays short.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ITER, ST_HOLD} gcd_state_e;
  typedef enum logic [1:0] {A_FROM_IN, A_FROM_B, A_FROM_DIFF} a_sel_e;
  typedef enum logic {B_FROM_IN, B_FROM_A} b_sel_e;
endpackage

// File: rtl/gcd_dpath.sv
module gcd_dpath
  import gcd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] in_a_i,
  input  logic [WIDTH-1:0] in_b_i,
  input  a_sel_e           a_sel_i,
  input  logic             a_en_i,
  input  b_sel_e           b_sel_i,
  input  logic             b_en_i,
  output logic             b_zero_o,
  output logic             a_lt_b_o,
  output logic [WIDTH-1:0] a_o
);
  logic [WIDTH-1:0] a_q, b_q, a_d, b_d, diff;

  assign diff = a_q - b_q;

  always_comb begin
    unique case (a_sel_i)
      A_FROM_IN:   a_d = in_a_i;
      A_FROM_B:    a_d = b_q;
      A_FROM_DIFF: a_d = diff;
      default:     a_d = a_q;
    endcase
  end

  assign b_d = (b_sel_i == B_FROM_A) ? a_q : in_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_en_i) a_q <= a_d;
      if (b_en_i) b_q <= b_d;
    end
  end

  assign b_zero_o = (b_q == '0);
  assign a_lt_b_o = (a_q < b_q);
  assign a_o      = a_q;
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   in_valid_i,
  input  logic   out_ready_i,
  input  logic   b_zero_i,
  input  logic   a_lt_b_i,
  output a_sel_e a_sel_o,
  output logic   a_en_o,
  output b_sel_e b_sel_o,
  output logic   b_en_o,
  output logic   in_ready_o,
  output logic   out_valid_o
);
  gcd_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    a_sel_o     = A_FROM_IN;
    b_sel_o     = B_FROM_IN;
    a_en_o      = 1'b0;
    b_en_o      = 1'b0;
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          a_en_o  = 1'b1;
          b_en_o  = 1'b1;
          state_d = ST_ITER;
        end
      end
      ST_ITER: begin
        if (a_lt_b_i) begin
          // swap: both registers load in the same cycle
          a_sel_o = A_FROM_B;
          b_sel_o = B_FROM_A;
          a_en_o  = 1'b1;
          b_en_o  = 1'b1;
        end else if (!b_zero_i) begin
          a_sel_o = A_FROM_DIFF;
          a_en_o  = 1'b1;
        end else begin
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        out_valid_o = 1'b1;
        if (out_ready_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/gcd_unit.sv
module gcd_unit
  import gcd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [WIDTH-1:0] in_a_i,
  input  logic [WIDTH-1:0] in_b_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [WIDTH-1:0] out_gcd_o
);
  a_sel_e a_sel;
  b_sel_e b_sel;
  logic   a_en, b_en, b_zero, a_lt_b;

  gcd_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .out_ready_i(out_ready_i),
    .b_zero_i   (b_zero),
    .a_lt_b_i   (a_lt_b),
    .a_sel_o    (a_sel),
    .a_en_o     (a_en),
    .b_sel_o    (b_sel),
    .b_en_o     (b_en),
    .in_ready_o (in_ready_o),
    .out_valid_o(out_valid_o)
  );

  gcd_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .in_a_i  (in_a_i),
    .in_b_i  (in_b_i),
    .a_sel_i (a_sel),
    .a_en_i  (a_en),
    .b_sel_i (b_sel),
    .b_en_i  (b_en),
    .b_zero_o(b_zero),
    .a_lt_b_o(a_lt_b),
    .a_o     (out_gcd_o)
  );
endmodule

// File: rtl/gcd_unit_chk.sv
module gcd_unit_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [WIDTH-1:0] in_a_i,
  input logic [WIDTH-1:0] in_b_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [WIDTH-1:0] out_gcd_o
);
  logic [WIDTH-1:0] cap_a, cap_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_a <= '0;
      cap_b <= '0;
    end else if (in_valid_i && in_ready_o) begin
      cap_a <= in_a_i;
      cap_b <= in_b_i;
    end
  end

  p_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> !in_ready_o);

  p_idle_stays_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && !in_valid_i |=> in_ready_o && !out_valid_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_gcd_o));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i |=> in_ready_o && !out_valid_o);

  p_zero_only_if_both_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (out_gcd_o == '0) |-> (cap_a == '0) && (cap_b == '0));

  p_divides_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (out_gcd_o != '0) |->
      ((cap_a % out_gcd_o) == '0) && ((cap_b % out_gcd_o) == '0));
endmodule

bind gcd_unit gcd_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .in_a_i     (in_a_i),
  .in_b_i     (in_b_i),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_gcd_o  (out_gcd_o)
);

// File: tb/gcd_unit_test.sv
module gcd_unit_test;
  localparam int W     = 8;
  localparam int LIMIT = 150000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic [W-1:0] in_a_i = '0;
  logic [W-1:0] in_b_i = '0;
  logic         out_valid_o;
  logic         out_ready_i = 1'b0;
  logic [W-1:0] out_gcd_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  gcd_unit #(.WIDTH(W)) uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_a_i     (in_a_i),
    .in_b_i     (in_b_i),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_gcd_o  (out_gcd_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_gcd(input int a, input int b);
    int x = a, y = b, t;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int ref_steps(input int a, input int b);
    int x = a, y = b, t, n = 0;
    forever begin
      if (x < y) begin
        t = x; x = y; y = t; n++;
      end else if (y != 0) begin
        x = x - y; n++;
      end else break;
    end
    return n;
  endfunction

  // One problem: idle gap, accept, optional busy pokes, stall, release.
  task automatic run_pair(input int a, input int b, input int gap,
                          input int stall, input bit poke, input string req);
    int exp_g   = ref_gcd(a, b);
    int exp_lat = ref_steps(a, b) + 1;
    int lat     = 0;
    logic [W-1:0] held;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk_i);
      chk(in_ready_o === 1'b1, "R2", "ready in idle gap", int'(in_ready_o), 1);
    end
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_a_i     = W'(a);
    in_b_i     = W'(b);
    @(negedge clk_i);
    // R3: keep offering garbage while busy; it must not be taken
    in_valid_i = poke;
    in_a_i     = W'($urandom);
    in_b_i     = W'($urandom);
    while (out_valid_o !== 1'b1 && lat < 2000) begin
      if (in_ready_o !== 1'b0)
        chk(1'b0, "R2", "ready while busy", int'(in_ready_o), 0);
      @(negedge clk_i);
      in_a_i = W'($urandom);
      in_b_i = W'($urandom);
      lat++;
    end
    in_valid_i = 1'b0;
    chk(lat == exp_lat, "R6", "latency", lat, exp_lat);
    chk(out_gcd_o == W'(exp_g), req, "result", int'(out_gcd_o), exp_g);
    held = out_gcd_o;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk_i);
      chk(out_valid_o === 1'b1 && out_gcd_o == held, "R7", "held result",
          int'(out_gcd_o), int'(held));
    end
    out_ready_i = 1'b1;
    @(negedge clk_i);
    out_ready_i = 1'b0;
    chk(out_valid_o === 1'b0 && in_ready_o === 1'b1, "R7", "release to idle",
        int'(out_valid_o), 0);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(out_valid_o === 1'b0, "R1", "valid in reset", int'(out_valid_o), 0);
    chk(in_ready_o === 1'b1, "R1", "ready in reset", int'(in_ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o === 1'b0 && in_ready_o === 1'b1, "R1", "after reset",
        int'(out_valid_o), 0);
  endtask

  task automatic t_reference_pair;
    run_pair(32, 48, 0, 0, 1'b0, "R6");
    chk(ref_steps(32, 48) == 6, "R6", "reference step count", ref_steps(32, 48), 6);
  endtask

  task automatic t_zero_cases;
    run_pair(0, 0, 1, 1, 1'b0, "R5");
    run_pair(0, 37, 0, 0, 1'b0, "R5");
    run_pair(91, 0, 2, 0, 1'b0, "R5");
    run_pair(255, 255, 0, 0, 1'b0, "R4");
    run_pair(255, 1, 0, 0, 1'b0, "R4");
  endtask

  task automatic t_busy_ignore;
    run_pair(84, 36, 0, 3, 1'b1, "R3");
    run_pair(17, 200, 1, 0, 1'b1, "R3");
  endtask

  task automatic t_stall;
    run_pair(120, 45, 0, 9, 1'b0, "R7");
  endtask

  task automatic t_random;
    for (int k = 0; k < 300; k++)
      run_pair(int'($urandom_range(255, 1)), int'($urandom_range(255, 1)),
               int'($urandom_range(3, 0)), int'($urandom_range(4, 0)),
               1'(($urandom & 1)), "R4");
  endtask

  // R8 observed at every falling edge
  always @(negedge clk_i)
    if (rst_ni && in_ready_o && out_valid_o)
      chk(1'b0, "R8", "ready and valid together", 1, 0);

  initial begin
    repeat (LIMIT) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_reference_pair();
    t_zero_cases();
    t_busy_ignore();
    t_stall();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule